// File: doc/BRIEF.md
# Core Regulator Control Register with Write Lock

This block is the register front end for an on-chip core voltage regulator. It holds one control word with a regulator-off bit, a trim (calibration) field and a write-once freeze bit. It shows whether the regulator output is ready, and it raises a maskable, sticky interrupt when that ready status goes from low to high. Software reaches it through a simple single-cycle register bus with address, write strobe, read strobe, write data and combinational read data.

The control word is guarded two ways. First, a write to it only takes effect if the bus access just before it was a key write to the unlock register naming the control word's offset. Second, once the freeze bit has been written to 1, the off bit, the trim field and the freeze bit itself can no longer change. Only a power-on reset clears them. A system reset (`rst_n`, synchronous) clears the rest of the block, but it leaves a frozen control word untouched.

Register offsets (byte addresses): control 0x00, status 0x04, interrupt enable 0x08, interrupt clear 0x0C, unlock 0x10.

Top module: `vreg_ctl`

## Requirements
- R1: After a power-on reset, `reg_disable_o` is 0, `reg_calib_o` equals `CAL_RST`, `irq_o` is 0, and reads of control, status and interrupt enable return 0 in every bit except the trim field.
- R2: An unlocked write to the control register (offset 0x00) loads the off bit from bit 0 and the trim field from bits [8 +: CAL_W]. Both appear on `reg_disable_o` / `reg_calib_o` after that clock edge and read back at the same positions. The freeze bit reads back at bit 31.
- R3: Status bit 0 (offset 0x04) is `reg_ready_i` registered by one clock edge. It is forced to 0 while the off bit is 1.
- R4: The interrupt flag (status bit 1) is set on the same edge where status bit 0 goes from 0 to 1, and only then. A steady high ready does not set it again.
- R5: A write to the control register is ignored unless the bus access immediately before it unlocked that offset.
- R6: An unlock is a write to offset 0x10 with key 0xA5 in bits [31:24] and the target offset in bits [7:0]. A wrong key, or another target offset, does not unlock the control register.
- R7: An unlock permits exactly one write to its target. Any other read or write in between cancels it. Idle cycles in between do not cancel it.
- R8: The flag stays set until a write with bit 0 = 1 to offset 0x0C. `irq_o` is high only while the flag is set and bit 0 of the enable register (offset 0x08) is 1.
- R9: Once the freeze bit has been written to 1 in an unlocked control write, later control writes are ignored, even when unlocked.
- R10: A system reset clears the off bit and the trim field to their reset values only when the control word is not frozen. It never clears the freeze bit. A power-on reset clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous system reset, active low |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (counts as a bus access) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| reg_ready_i | input | 1 | Regulator output has reached target |
| reg_disable_o | output | 1 | Regulator off request |
| reg_calib_o | output | CAL_W | Regulator trim value |
| irq_o | output | 1 | Ready-rise interrupt |

## Verification
The assertions assume that `wr_en` and `rd_en` are never both high, and that `reg_ready_i` is a clean level already synchronous to `clk`. They also assume a bus access lasts exactly one cycle. The bench drives every input on the falling edge and issues one access per task call, with idle cycles between some of them. The ready input changes only on falling edges, so each rise is seen as a single clean transition. Random addresses are drawn from the five defined offsets plus one unmapped offset. During the random phase the freeze bit is always written as 0, so the freeze case is only exercised in the directed tests.

// File: rtl/vreg_ctl.sv
module vreg_ctl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CAL_W  = 6,
  parameter logic [CAL_W-1:0]  CAL_RST  = 6'h20,
  parameter logic [7:0]        KEY      = 8'hA5,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h00,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] IEN_OFS  = 8'h08,
  parameter logic [ADDR_W-1:0] ICLR_OFS = 8'h0C,
  parameter logic [ADDR_W-1:0] UNLK_OFS = 8'h10
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              reg_ready_i,
  output logic              reg_disable_o,
  output logic [CAL_W-1:0]  reg_calib_o,
  output logic              irq_o
);
  localparam int CAL_LSB = 8;
  localparam int FRZ_BIT = DATA_W - 1;
  localparam int KEY_LSB = DATA_W - 8;

  logic              off_q, frz_q, rdy_q, flag_q, ien_q, unl_q;
  logic [CAL_W-1:0]  cal_q;
  logic [ADDR_W-1:0] unl_ofs_q;

  logic access, key_wr, ctrl_wr, clr_wr, rdy_nxt, rise;

  assign access  = wr_en | rd_en;
  assign key_wr  = wr_en && addr == UNLK_OFS && wdata[KEY_LSB +: 8] == KEY;
  assign ctrl_wr = wr_en && addr == CTRL_OFS && unl_q && unl_ofs_q == CTRL_OFS && !frz_q;
  assign clr_wr  = wr_en && addr == ICLR_OFS && wdata[0];
  assign rdy_nxt = reg_ready_i & ~off_q;
  assign rise    = rdy_nxt & ~rdy_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      off_q <= 1'b0;
      cal_q <= CAL_RST;
      frz_q <= 1'b0;
    end else if (!rst_n) begin
      if (!frz_q) begin
        off_q <= 1'b0;
        cal_q <= CAL_RST;
      end
    end else if (ctrl_wr) begin
      off_q <= wdata[0];
      cal_q <= wdata[CAL_LSB +: CAL_W];
      frz_q <= wdata[FRZ_BIT];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rdy_q     <= 1'b0;
      flag_q    <= 1'b0;
      ien_q     <= 1'b0;
      unl_q     <= 1'b0;
      unl_ofs_q <= '0;
    end else if (!rst_n) begin
      rdy_q     <= 1'b0;
      flag_q    <= 1'b0;
      ien_q     <= 1'b0;
      unl_q     <= 1'b0;
      unl_ofs_q <= '0;
    end else begin
      rdy_q  <= rdy_nxt;
      flag_q <= rise | (flag_q & ~clr_wr);
      if (wr_en && addr == IEN_OFS) ien_q <= wdata[0];
      if (key_wr) begin
        unl_q     <= 1'b1;
        unl_ofs_q <= wdata[ADDR_W-1:0];
      end else if (access) begin
        unl_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      CTRL_OFS: begin
        rdata[0]                = off_q;
        rdata[CAL_LSB +: CAL_W] = cal_q;
        rdata[FRZ_BIT]          = frz_q;
      end
      STAT_OFS: rdata[1:0] = {flag_q, rdy_q};
      IEN_OFS:  rdata[0]   = ien_q;
      default:  rdata      = '0;
    endcase
  end

  assign reg_disable_o = off_q;
  assign reg_calib_o   = cal_q;
  assign irq_o         = flag_q & ien_q;

  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr_en && addr == CTRL_OFS && !unl_q) |=> ($stable(off_q) && $stable(cal_q) && $stable(frz_q))); // R5
  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    frz_q |=> (frz_q && $stable(off_q) && $stable(cal_q))); // R9
  AST_FLAG_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(flag_q) |-> $rose(rdy_q)); // R4
  AST_UNLOCK_CANCEL: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (access && !(wr_en && addr == UNLK_OFS)) |=> !unl_q); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (flag_q && !clr_wr) |=> flag_q); // R8
  AST_NOT_READY_WHEN_OFF: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (off_q && $stable(off_q)) |-> !rdy_q); // R3
endmodule

// File: tb/vreg_ctl_bench.sv
module vreg_ctl_bench;
  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_IEN = 8'h08,
                         A_CLR = 8'h0C, A_UNLK = 8'h10, A_NONE = 8'h14;
  localparam logic [5:0] CAL_RST = 6'h20;

  logic clk = 0, por_n = 0, rst_n = 0;
  logic [7:0] addr = '0;
  logic wr_en = 0, rd_en = 0, rdy_in = 0;
  logic [31:0] wdata = '0, rdata;
  logic dis_o, irq;
  logic [5:0] cal_o;

  int checks = 0, errors = 0;
  logic m_off, m_frz, m_rdy, m_flag, m_en, m_unl;
  logic [5:0] m_cal;
  logic [7:0] m_uofs;

  vreg_ctl u_vreg_ctl (.clk(clk), .por_n(por_n), .rst_n(rst_n), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .reg_ready_i(rdy_in), .reg_disable_o(dis_o), .reg_calib_o(cal_o), .irq_o(irq));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mread(input logic [7:0] a);
    logic [31:0] r = '0;
    case (a)
      A_CTRL: begin r[0] = m_off; r[13:8] = m_cal; r[31] = m_frz; end
      A_STAT: r[1:0] = {m_flag, m_rdy};
      A_IEN:  r[0] = m_en;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string rtag(input logic [7:0] a);
    return a == A_CTRL ? "R2" : a == A_STAT ? "R3" : a == A_IEN ? "R8" : "R1";
  endfunction

  task automatic m_por();
    m_off = 0; m_cal = CAL_RST; m_frz = 0;
    m_rdy = 0; m_flag = 0; m_en = 0; m_unl = 0; m_uofs = '0;
  endtask

  task automatic m_step(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d);
    logic nr, rise, clr;
    nr = rdy_in & ~m_off;
    rise = nr & ~m_rdy;
    clr = w && a == A_CLR && d[0];
    if (w && a == A_CTRL && m_unl && m_uofs == A_CTRL && !m_frz) begin
      m_off = d[0]; m_cal = d[13:8]; m_frz = d[31];
    end
    if (w && a == A_IEN) m_en = d[0];
    if (w && a == A_UNLK && d[31:24] == 8'hA5) begin m_unl = 1; m_uofs = d[7:0]; end
    else if (w || r) m_unl = 0;
    m_flag = rise | (m_flag & ~clr);
    m_rdy = nr;
  endtask

  task automatic outs();
    chk(dis_o === m_off, "R2", {31'b0, dis_o}, {31'b0, m_off});
    chk(cal_o === m_cal, "R2", {26'b0, cal_o}, {26'b0, m_cal});
    chk(irq === (m_flag & m_en), "R4", {31'b0, irq}, {31'b0, m_flag & m_en});
  endtask

  task automatic cyc(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d);
    addr = a; wr_en = w; rd_en = r; wdata = d;
    #1;
    if (r) chk(rdata === mread(a), rtag(a), rdata, mread(a));
    @(posedge clk);
    m_step(w, r, a, d);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    outs();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d); cyc(1, 0, a, d); endtask
  task automatic rd(input logic [7:0] a); cyc(0, 1, a, '0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(0, 0, A_NONE, '0); endtask
  task automatic unlock(); wr(A_UNLK, 32'hA500_0000 | A_CTRL); endtask

  task automatic sysrst();
    rst_n = 0;
    @(posedge clk);
    if (!m_frz) begin m_off = 0; m_cal = CAL_RST; end
    m_rdy = 0; m_flag = 0; m_en = 0; m_unl = 0; m_uofs = '0;
    @(negedge clk); rst_n = 1; outs();
  endtask

  task automatic por();
    por_n = 0; rst_n = 0; #3; m_por();
    @(negedge clk); por_n = 1; rst_n = 1; outs();
  endtask

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_por();
    @(negedge clk); @(negedge clk);
    por_n = 1; rst_n = 1;
    // R1 reset state
    chk(dis_o === 0 && cal_o === CAL_RST && irq === 0, "R1", {dis_o, cal_o, irq}, {1'b0, CAL_RST, 1'b0});
    rd(A_CTRL); rd(A_STAT); rd(A_IEN);
    // R5 locked write ignored
    wr(A_CTRL, 32'h0000_1501);
    chk(dis_o === 0, "R5", dis_o, 0);
    // R6 wrong key / wrong offset
    wr(A_UNLK, 32'h5A00_0000); wr(A_CTRL, 32'h1);
    chk(dis_o === 0, "R6", dis_o, 0);
    wr(A_UNLK, 32'hA500_0008); wr(A_CTRL, 32'h1);
    chk(dis_o === 0, "R6", dis_o, 0);
    // R2 unlocked write
    unlock(); wr(A_CTRL, 32'h0000_1501);
    chk(dis_o === 1 && cal_o === 6'h15, "R2", {dis_o, cal_o}, {1'b1, 6'h15});
    rd(A_CTRL);
    // R7 single write, cancel by read, idle ok
    wr(A_CTRL, 32'h0);
    chk(dis_o === 1, "R7", dis_o, 1);
    unlock(); rd(A_STAT); wr(A_CTRL, 32'h0);
    chk(dis_o === 1, "R7", dis_o, 1);
    unlock(); idle(3); wr(A_CTRL, 32'h0000_0A00);
    chk(dis_o === 0 && cal_o === 6'h0A, "R7", {dis_o, cal_o}, {1'b0, 6'h0A});
    // R3 / R4 / R8
    wr(A_IEN, 32'h1);
    rdy_in = 1; idle(1);
    chk(irq === 1, "R4", irq, 1);
    rd(A_STAT);
    wr(A_CLR, 32'h1); idle(3);
    chk(irq === 0, "R4", irq, 0);
    wr(A_CLR, 32'h0); rdy_in = 0; idle(1); rdy_in = 1; idle(1);
    chk(irq === 1, "R4", irq, 1);
    wr(A_CLR, 32'h0); idle(2);
    chk(irq === 1, "R8", irq, 1);
    wr(A_IEN, 32'h0);
    chk(irq === 0, "R8", irq, 0);
    wr(A_CLR, 32'h1);
    unlock(); wr(A_CTRL, 32'h1); idle(1); rd(A_STAT);
    chk(rdata !== 32'hx, "R3", rdata, mread(A_STAT));
    unlock(); wr(A_CTRL, 32'h0); idle(1); rd(A_STAT);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 9);
      logic [7:0] a;
      case ($urandom_range(0, 5))
        0: a = A_CTRL; 1: a = A_STAT; 2: a = A_IEN; 3: a = A_CLR; 4: a = A_UNLK; default: a = A_NONE;
      endcase
      if ($urandom_range(0, 7) == 0) rdy_in = ~rdy_in;
      if (k < 3) unlock();
      else if (k < 5) wr(A_CTRL, $urandom & 32'h7FFF_FFFF);
      else if (k < 7) rd(a);
      else if (k < 8) wr(a, $urandom & 32'h7FFF_FFFF);
      else idle(1);
    end
    // R10 non-frozen system reset
    unlock(); wr(A_CTRL, 32'h0000_0301); sysrst();
    chk(dis_o === 0 && cal_o === CAL_RST, "R10", {dis_o, cal_o}, {1'b0, CAL_RST});
    // R9 freeze
    unlock(); wr(A_CTRL, 32'h8000_0A01);
    unlock(); wr(A_CTRL, 32'h0000_0000);
    chk(dis_o === 1 && cal_o === 6'h0A, "R9", {dis_o, cal_o}, {1'b1, 6'h0A});
    rd(A_CTRL);
    sysrst();
    chk(dis_o === 1 && cal_o === 6'h0A, "R10", {dis_o, cal_o}, {1'b1, 6'h0A});
    rd(A_CTRL);
    por();
    chk(dis_o === 0 && cal_o === CAL_RST, "R10", {dis_o, cal_o}, {1'b0, CAL_RST});
    rd(A_CTRL);
    unlock(); wr(A_CTRL, 32'h1);
    chk(dis_o === 1, "R10", dis_o, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule